// File: doc/BRIEF.md
# Vertical-Crosswise Column-Sum Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. Every one of the 64 single-bit partial products is formed at once as the AND of one bit of A with one bit of B. The partial products are then reduced column by column. Column k takes every partial product whose bit indices add up to k, together with the carries that earlier columns send into it, and counts the ones among them.

Bit 0 of a column's count is product bit k. Bit 1 of the count goes to column k+1, bit 2 to column k+2 and bit 3 to column k+3. The count is formed by a 7:2 cell and a 4:2 cell working side by side, and one short add joins their outputs. Both cells are built from 3:2 cells and half adders, so no column holds a long ripple chain. Because 255 × 255 fits in 16 bits, the carries that would leave bit 15 are always zero.

A parameter can add one output register with a synchronous active-high reset. When it is present, a valid flag passes through the same register stage so that each product stays aligned with the inputs it came from. Without the register, the product follows the operands in the same cycle and the valid flag passes straight through.

Top module: `vcm_mult`

## Requirements
- R1: With the output register disabled (REG_OUT=0), p_o equals the unsigned product a_i × b_i in the same cycle for all 65536 operand pairs.
- R2: With the output register enabled (REG_OUT=1, the default), p_o holds the product of the a_i and b_i values sampled at the previous rising clock edge, for every operand pair.
- R3: The maximum product 0xFF × 0xFF gives 0xFE01, and no column produces a carry whose weight lies above bit 15.
- R4: With REG_OUT=1, a rising clock edge while rst_i is 1 sets p_o to 0x0000 and vld_o to 0, whatever the operands are.
- R5: With REG_OUT=1, vld_o equals the value vld_i had at the previous rising edge, unless that edge was a reset edge.
- R6: A zero operand gives 0x0000, an operand of 0x01 gives the other operand unchanged, and 0x80 × 0x80 gives 0x4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| vld_i | input | 1 | Valid tag that travels with the operands |
| a_i | input | 8 | Unsigned operand A |
| b_i | input | 8 | Unsigned operand B |
| p_o | output | 16 | Unsigned product |
| vld_o | output | 1 | Valid tag aligned with p_o |

## Verification
The bench builds two instances side by side. One uses REG_OUT=1, which brings the one-cycle latency, the valid alignment and the reset clearing within reach. The other uses REG_OUT=0, which exposes the column tree directly so that every operand pair can be checked in the cycle it is applied. Both instances see the full 256 × 256 operand sweep, followed by the corner operands 0x00, 0x01, 0x80 and 0xFF in every combination. The maximum product reaches the highest columns, where a stray carry above bit 15 would show.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    localparam int OP_W    = 8;
    localparam int PROD_W  = 2 * OP_W;
    localparam int NCOL    = PROD_W;
    localparam int N_FWD   = 3;
    localparam int CNT_W   = N_FWD + 1;
    localparam int SLOT_PP = OP_W;
    localparam int SLOTS   = 14;
    localparam int SPILL_W = NCOL * N_FWD;

    typedef struct packed {
        logic c;
        logic s;
    } sc_t;

    function automatic sc_t fa3(input logic x, input logic y, input logic z);
        sc_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (z & (x ^ y));
        return r;
    endfunction

    function automatic sc_t ha2(input logic x, input logic y);
        sc_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

    // four data bits plus one carry-in, 3-bit count
    function automatic logic [2:0] cmp42(input logic [3:0] d, input logic ci);
        sc_t f1, f2, h1;
        f1 = fa3(d[0], d[1], d[2]);
        f2 = fa3(f1.s, d[3], ci);
        h1 = ha2(f1.c, f2.c);
        return {h1.c, h1.s, f2.s};
    endfunction

    // seven data bits plus two carry-ins, 4-bit count, five 3:2 cells
    function automatic logic [3:0] cmp72(input logic [6:0] d, input logic [1:0] ci);
        sc_t f1, f2, f3, f4, f5, h1, h2;
        f1 = fa3(d[0], d[1], d[2]);
        f2 = fa3(d[3], d[4], d[5]);
        f3 = fa3(d[6], ci[0], ci[1]);
        f4 = fa3(f1.s, f2.s, f3.s);
        f5 = fa3(f1.c, f2.c, f3.c);
        h1 = ha2(f5.s, f4.c);
        h2 = ha2(f5.c, h1.c);
        return {h2.c, h2.s, h1.s, f4.s};
    endfunction

endpackage

// File: rtl/vcm_col_count.sv
module vcm_col_count
    import vcm_pkg::*;
(
    input  logic [SLOTS-1:0] bits_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [3:0] part72;
    logic [2:0] part42;

    always_comb begin
        part72 = cmp72(bits_i[6:0], bits_i[8:7]);
        part42 = cmp42(bits_i[12:9], bits_i[13]);
        cnt_o  = CNT_W'(part72) + CNT_W'({1'b0, part42});
    end

    // R1: each column count equals the number of ones fed into it
    always_comb begin
        a_r1_col_count: assert (cnt_o == CNT_W'($countones(bits_i)));
    end

endmodule

// File: rtl/vcm_out_stage.sv
module vcm_out_stage
    import vcm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic [PROD_W-1:0] p_o,
    output logic              vld_o
);

    if (REG_OUT) begin : g_reg
        logic [PROD_W-1:0] p_q;
        logic              v_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                p_q <= '0;
                v_q <= 1'b0;
            end else begin
                p_q <= prod_i;
                v_q <= vld_i;
            end
        end

        assign p_o   = p_q;
        assign vld_o = v_q;

        a_r2_reg_product: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(!rst_i) |-> (p_o == PROD_W'($past(a_i)) * PROD_W'($past(b_i))));

        a_r5_valid_delay: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> (vld_o == $past(vld_i)));

        a_r4_reset_clear: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(rst_i) |-> (p_o == '0 && !vld_o));
    end else begin : g_comb
        assign p_o   = prod_i;
        assign vld_o = vld_i;

        // R1: combinational path matches the arithmetic product
        always_comb begin
            a_r1_comb_product: assert (p_o == PROD_W'(a_i) * PROD_W'(b_i));
        end
    end

endmodule

// File: rtl/vcm_mult.sv
module vcm_mult
    import vcm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    output logic [PROD_W-1:0] p_o,
    output logic              vld_o
);

    logic [PROD_W-1:0]  prod;
    logic [SPILL_W-1:0] spill;

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        logic [SLOTS-1:0] slots;
        logic [CNT_W-1:0] cnt;

        // partial-product slots, one per A bit index
        for (genvar i = 0; i < SLOT_PP; i++) begin : g_pp
            if ((k - i) >= 0 && (k - i) < OP_W) begin : g_and
                assign slots[i] = a_i[i] & b_i[k-i];
            end else begin : g_none
                assign slots[i] = 1'b0;
            end
        end

        // carries arriving from columns k-1, k-2, k-3
        for (genvar d = 1; d <= N_FWD; d++) begin : g_cin
            if (k >= d) begin : g_from
                assign slots[SLOT_PP+d-1] = g_col[k-d].cnt[d];
            end else begin : g_zero
                assign slots[SLOT_PP+d-1] = 1'b0;
            end
        end

        assign slots[SLOTS-1:SLOT_PP+N_FWD] = '0;

        vcm_col_count i_cnt (
            .bits_i (slots),
            .cnt_o  (cnt)
        );

        assign prod[k] = cnt[0];

        // carries that would land above the top column
        for (genvar d = 1; d <= N_FWD; d++) begin : g_out
            if (k + d >= NCOL) begin : g_spill
                assign spill[k*N_FWD+d-1] = cnt[d];
            end else begin : g_kept
                assign spill[k*N_FWD+d-1] = 1'b0;
            end
        end
    end

    // R3: no carry escapes beyond the most significant product bit
    always_comb begin
        a_r3_no_overflow: assert (spill == '0);
    end

    vcm_out_stage #(
        .REG_OUT (REG_OUT)
    ) i_out (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .vld_i  (vld_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_i (prod),
        .p_o    (p_o),
        .vld_o  (vld_o)
    );

endmodule

// File: tb/test_vcm_mult.sv
module test_vcm_mult;

    logic        clk = 1'b0;
    logic        rst;
    logic        vld;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] p_r;
    logic        v_r;
    logic [15:0] p_c;
    logic        v_c;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    vcm_mult #(.REG_OUT(1'b1)) i_vcm_mult (
        .clk_i (clk), .rst_i (rst), .vld_i (vld),
        .a_i (a), .b_i (b), .p_o (p_r), .vld_o (v_r)
    );

    vcm_mult #(.REG_OUT(1'b0)) i_vcm_mult_comb (
        .clk_i (clk), .rst_i (rst), .vld_i (vld),
        .a_i (a), .b_i (b), .p_o (p_c), .vld_o (v_c)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%02h b=%02h actual=%04h expected=%04h", tag, a, b, act, exp);
        end
    endtask

    // apply one operand pair just after a falling edge, check both instances
    task automatic apply(input logic [7:0] av, input logic [7:0] bv, input logic vv,
                         input string tag);
        int unsigned prod_model;
        prod_model = int'(av) * int'(bv);
        a   = av;
        b   = bv;
        vld = vv;
        #1;
        chk({tag, " comb"}, p_c, prod_model[15:0]);
        @(negedge clk);
        chk("R2 registered product", p_r, prod_model[15:0]);
        chk("R5 valid delay", {15'd0, v_r}, {15'd0, vv});
    endtask

    initial begin
        logic [7:0] corner [4];
        corner[0] = 8'h00;
        corner[1] = 8'h01;
        corner[2] = 8'h80;
        corner[3] = 8'hFF;

        rst = 1'b1;
        vld = 1'b1;
        a   = 8'hA5;
        b   = 8'h3C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 reset product", p_r, 16'h0000);
        chk("R4 reset valid", {15'd0, v_r}, 16'h0000);
        rst = 1'b0;

        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                apply(8'(ia), 8'(ib), logic'((ia ^ (ib >> 1)) & 1), "R1 sweep");
            end
        end

        for (int ca = 0; ca < 4; ca++) begin
            for (int cb = 0; cb < 4; cb++) begin
                apply(corner[ca], corner[cb], logic'(cb & 1), "R6 corner");
            end
        end

        apply(8'h00, 8'h5A, 1'b1, "R6 zero operand");
        apply(8'h01, 8'hC3, 1'b0, "R6 unit operand");
        apply(8'h80, 8'h80, 1'b1, "R6 top bits");
        apply(8'hFF, 8'hFF, 1'b1, "R3 maximum");
        chk("R3 maximum value", p_c, 16'hFE01);

        // reset in mid-run clears the register despite live operands
        a   = 8'hFF;
        b   = 8'hFF;
        vld = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R4 mid-run reset product", p_r, 16'h0000);
        chk("R4 mid-run reset valid", {15'd0, v_r}, 16'h0000);
        rst = 1'b0;
        apply(8'h7F, 8'h81, 1'b1, "R1 after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule